// File: doc/BRIEF.md
# Bistable Fault Pair Monitor

This block supervises a controller that reports its own health over two complementary wires. While the controller runs cleanly, one wire sits high and the other low. A detected internal fault flips both wires. The monitor brings the pair into its clock domain and filters out short disturbances. It then classifies the settled value as healthy, faulted or malformed. A malformed value is one where both wires agree, which cannot happen on a working link. Both faulted and malformed values lead to a reaction.

The reaction is selected at initialisation through a two-bit setting. Bit 0 requests a timed active-low reset of the supervised controller. Bit 1 requests a latched active-low fail-safe output that only an explicit clear pulse releases. The setting is captured only while monitoring is disabled. The enable input marks the end of the supervised controller's own reset and self-test phase. During that phase its outputs float, so the pair carries no meaning and is ignored. A two-bit status output shows the current classification.

Top module: `fault_pair_monitor`

## Requirements
- R1: After the synchronous reset, `rst_n_o` and `safe_n_o` are 1 and `status_o` is 0.
- R2: `pair_in[1]` is the first wire and `pair_in[0]` the second. The value 2'b01 is healthy and gives status 1 with no reaction. Status codes are: 0 = monitoring disabled, 1 = healthy, 2 = fault, 3 = malformed.
- R3: With monitoring enabled, a held pair value of 2'b10 gives status 2. The status and any reaction appear at the seventh rising edge after the input changes: two synchroniser stages, four filter samples and one output register.
- R4: A held value of 2'b00 or 2'b11 gives status 3. It triggers the same reaction path as a fault.
- R5: A pair value seen for fewer than 4 consecutive synchronised samples changes neither status nor outputs.
- R6: While `mon_en` is 0, the status is 0 and no new reaction starts, whatever the pair carries.
- R7: When setting bit 0 is set, each error episode drives `rst_n_o` low for exactly RST_HOLD cycles (default 8). An error episode is a transition from healthy or disabled to fault or malformed while enabled. An error that persists produces no second pulse.
- R8: When setting bit 1 is set, an error episode drives `safe_n_o` low. It stays low until `safe_clr` is pulsed while no enabled error is present. A clear pulse during an error is ignored.
- R9: `react_cfg` is captured only while `mon_en` is 0. Changes while monitoring is enabled have no effect.
- R10: With the setting at 2'b00, errors update the status but drive neither reaction output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Monitoring enable; high once the supervised controller leaves reset and self-test |
| pair_in | input | 2 | Complementary fault wires, {first, second} |
| react_cfg | input | 2 | Reaction setting: bit 0 reset pulse, bit 1 fail-safe latch |
| safe_clr | input | 1 | Pulse that releases the latched fail-safe output |
| rst_n_o | output | 1 | Active-low reset to the supervised controller |
| safe_n_o | output | 1 | Active-low fail-safe output |
| status_o | output | 2 | Classification of the filtered pair |

## Verification
The hardest state to reach is a fail-safe latch that has to survive a clear attempt. The bench pulses `safe_clr` while the fault is still held past the filter, then removes the fault and shows the latch is still set until a second, valid clear. A second hard case is a fault that stays present for a long time. The bench holds one for well beyond the reset hold time to confirm that only one pulse is produced. It then drops the fault, lets it settle as healthy, and raises it again to obtain a fresh pulse. Glitches that are one sample short of the filter depth, and a setting change made while monitoring is enabled, are driven as directed cases.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_OK    = 2'd1,
    ST_FAULT = 2'd2,
    ST_BAD   = 2'd3
  } pair_status_e;

  localparam logic [1:0] PAIR_HEALTHY = 2'b01;
  localparam logic [1:0] PAIR_FAULTED = 2'b10;

  function automatic pair_status_e classify_pair(input logic [1:0] p);
    case (p)
      PAIR_HEALTHY: classify_pair = ST_OK;
      PAIR_FAULTED: classify_pair = ST_FAULT;
      default:      classify_pair = ST_BAD;
    endcase
  endfunction

endpackage

// File: rtl/fpm_sync.sv
module fpm_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/fpm_filter.sv
module fpm_filter #(
  parameter int          WIDTH   = 2,
  parameter int          DEPTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] d_prev;
  logic [CW-1:0]    run;
  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_prev <= RST_VAL;
      run    <= CW'(DEPTH);
      q_r    <= RST_VAL;
    end else begin
      d_prev <= d;
      if (d != d_prev) begin
        run <= CW'(1);
      end else if (run < CW'(DEPTH)) begin
        run <= run + CW'(1);
      end
      if (d == d_prev && run == CW'(DEPTH - 1)) begin
        q_r <= d;
      end
    end
  end

  assign q = q_r;

endmodule

// File: rtl/fpm_react.sv
module fpm_react #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic err_now,
  input  logic want_rst,
  input  logic want_safe,
  input  logic clr,
  output logic rst_n,
  output logic safe_n
);

  localparam int CW = $clog2(HOLD + 1);

  logic          err_seen;
  logic          episode;
  logic          live_err;
  logic [CW-1:0] hold_cnt;

  assign live_err = en & err_now;
  assign episode  = live_err & ~err_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_seen <= 1'b0;
      hold_cnt <= '0;
      rst_n    <= 1'b1;
      safe_n   <= 1'b1;
    end else begin
      err_seen <= live_err;

      if (episode && want_rst) begin
        hold_cnt <= CW'(HOLD);
        rst_n    <= 1'b0;
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - CW'(1);
        if (hold_cnt == CW'(1)) rst_n <= 1'b1;
      end

      if (episode && want_safe) begin
        safe_n <= 1'b0;
      end else if (clr && !live_err) begin
        safe_n <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fault_pair_monitor.sv
module fault_pair_monitor
  import fpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int RST_HOLD    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mon_en,
  input  logic [1:0] pair_in,
  input  logic [1:0] react_cfg,
  input  logic       safe_clr,
  output logic       rst_n_o,
  output logic       safe_n_o,
  output logic [1:0] status_o
);

  localparam int PW = 2;

  logic [PW-1:0] sync_q;
  logic [PW-1:0] filt_q;
  logic [1:0]    cfg_q;
  pair_status_e  code;
  logic          err_now;
  logic [1:0]    status_q;

  fpm_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES), .RST_VAL(PAIR_HEALTHY)) sync_i (
    .clk(clk), .rst(rst), .d(pair_in), .q(sync_q)
  );

  fpm_filter #(.WIDTH(PW), .DEPTH(FILT_LEN), .RST_VAL(PAIR_HEALTHY)) filt_i (
    .clk(clk), .rst(rst), .d(sync_q), .q(filt_q)
  );

  assign code    = classify_pair(filt_q);
  assign err_now = (code == ST_FAULT) || (code == ST_BAD);

  // Reaction setting is frozen once monitoring starts.
  always_ff @(posedge clk) begin
    if (rst)          cfg_q <= 2'b11;
    else if (!mon_en) cfg_q <= react_cfg;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= ST_OFF;
    else     status_q <= mon_en ? code : ST_OFF;
  end

  fpm_react #(.HOLD(RST_HOLD)) react_i (
    .clk(clk), .rst(rst), .en(mon_en), .err_now(err_now),
    .want_rst(cfg_q[0]), .want_safe(cfg_q[1]), .clr(safe_clr),
    .rst_n(rst_n_o), .safe_n(safe_n_o)
  );

  assign status_o = status_q;

  // R5: the filtered pair only moves to a value the synchroniser held steady
  a_r5_filter_steady: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> ($past(sync_q, 1) == $past(sync_q, 2)));

  // R6 / R7: a reset pulse only starts while enabled with the reset reaction chosen
  a_r7_rst_needs_cfg: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_o) |-> ($past(mon_en) && $past(cfg_q[0])));

  // R8: fail-safe only falls together with an error status
  a_r8_safe_with_error: assert property (@(posedge clk) disable iff (rst)
    $fell(safe_n_o) |-> (status_o == ST_FAULT || status_o == ST_BAD));

  // R8: fail-safe only releases after a clear request
  a_r8_safe_release: assert property (@(posedge clk) disable iff (rst)
    $rose(safe_n_o) |-> $past(safe_clr));

  // R9: setting does not move while monitoring was enabled
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(mon_en) |-> $stable(cfg_q));

  // R6: status reads disabled whenever enable was low
  a_r6_status_off: assert property (@(posedge clk) disable iff (rst)
    !$past(mon_en) |-> (status_o == ST_OFF));

endmodule

// File: tb/fault_pair_monitor_tb_top.sv
module fault_pair_monitor_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       mon_en;
  logic [1:0] pair_in;
  logic [1:0] react_cfg;
  logic       safe_clr;
  logic       rst_n_o;
  logic       safe_n_o;
  logic [1:0] status_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  fault_pair_monitor dut_i (
    .clk(clk), .rst(rst), .mon_en(mon_en), .pair_in(pair_in),
    .react_cfg(react_cfg), .safe_clr(safe_clr),
    .rst_n_o(rst_n_o), .safe_n_o(safe_n_o), .status_o(status_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  // outputs packed {status, rst_n, safe_n}
  function automatic logic [3:0] outs();
    return {status_o, rst_n_o, safe_n_o};
  endfunction

  task automatic settle(input logic [1:0] cfg);
    @(negedge clk);
    mon_en = 1'b0; react_cfg = cfg; pair_in = 2'b01;
    repeat (20) @(negedge clk);
    safe_clr = 1'b1;
    @(negedge clk);
    safe_clr = 1'b0;
    mon_en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // {cfg, pair, exp_status, exp_rst_n, exp_safe_n}
  localparam logic [7:0] VEC [8] = '{
    {2'b01, 2'b10, 2'd2, 1'b0, 1'b1},
    {2'b10, 2'b10, 2'd2, 1'b1, 1'b0},
    {2'b11, 2'b00, 2'd3, 1'b0, 1'b0},
    {2'b01, 2'b11, 2'd3, 1'b0, 1'b1},
    {2'b00, 2'b10, 2'd2, 1'b1, 1'b1},
    {2'b10, 2'b01, 2'd1, 1'b1, 1'b1},
    {2'b11, 2'b11, 2'd3, 1'b0, 1'b0},
    {2'b00, 2'b00, 2'd3, 1'b1, 1'b1}
  };

  initial begin
    rst = 1'b1; mon_en = 1'b0; pair_in = 2'b01; react_cfg = 2'b00; safe_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", outs(), {2'd0, 1'b1, 1'b1});

    // Table walk: R2, R3, R4, R10
    for (int i = 0; i < 8; i++) begin
      settle(VEC[i][7:6]);
      chk("R2 healthy before change", outs(), {2'd1, 1'b1, 1'b1});
      pair_in = VEC[i][5:4];
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R3 no change before edge 7", outs(), {2'd1, 1'b1, 1'b1});
      @(posedge clk);
      @(negedge clk);
      chk("R3/R4/R10 result at edge 7", outs(), VEC[i][3:0]);
    end

    // R5: glitch of 3 samples is filtered
    settle(2'b11);
    pair_in = 2'b10;
    repeat (3) @(negedge clk);
    pair_in = 2'b01;
    repeat (12) @(negedge clk);
    chk("R5 short fault ignored", outs(), {2'd1, 1'b1, 1'b1});
    pair_in = 2'b00;
    repeat (3) @(negedge clk);
    pair_in = 2'b01;
    repeat (12) @(negedge clk);
    chk("R5 short malformed ignored", outs(), {2'd1, 1'b1, 1'b1});

    // R7: pulse length and one pulse per episode
    settle(2'b01);
    pair_in = 2'b10;
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk("R7 pulse starts", {3'b0, rst_n_o}, 4'd0);
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk("R7 still low at cycle 8", {3'b0, rst_n_o}, 4'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 released after 8 cycles", {3'b0, rst_n_o}, 4'd1);
    repeat (20) @(negedge clk);
    chk("R7 persistent error no second pulse", outs(), {2'd2, 1'b1, 1'b1});
    pair_in = 2'b01;
    repeat (12) @(negedge clk);
    pair_in = 2'b10;
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk("R7 new episode new pulse", {3'b0, rst_n_o}, 4'd0);

    // R8: latch and clear rules
    settle(2'b10);
    pair_in = 2'b10;
    repeat (10) @(negedge clk);
    chk("R8 fail-safe set", {3'b0, safe_n_o}, 4'd0);
    safe_clr = 1'b1;
    @(negedge clk);
    safe_clr = 1'b0;
    @(negedge clk);
    chk("R8 clear during error ignored", {3'b0, safe_n_o}, 4'd0);
    pair_in = 2'b01;
    repeat (10) @(negedge clk);
    chk("R8 latched after fault gone", {3'b0, safe_n_o}, 4'd0);
    safe_clr = 1'b1;
    @(negedge clk);
    safe_clr = 1'b0;
    chk("R8 clear releases", {3'b0, safe_n_o}, 4'd1);

    // R6: disabled monitor ignores the pair
    @(negedge clk);
    mon_en = 1'b0; react_cfg = 2'b11; pair_in = 2'b01;
    repeat (20) @(negedge clk);
    pair_in = 2'b10;
    repeat (15) @(negedge clk);
    chk("R6 fault while disabled", outs(), {2'd0, 1'b1, 1'b1});
    pair_in = 2'b11;
    repeat (15) @(negedge clk);
    chk("R6 malformed while disabled", outs(), {2'd0, 1'b1, 1'b1});

    // R9: setting change while enabled has no effect
    settle(2'b01);
    react_cfg = 2'b10;
    repeat (3) @(negedge clk);
    pair_in = 2'b10;
    repeat (10) @(negedge clk);
    chk("R9 old setting kept", outs(), {2'd2, 1'b0, 1'b1});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule